// File: doc/BRIEF.md
# Keyed Watchdog Countdown Timer

The block is a watchdog counter reached through a small 32-bit register bus. Software places a reload value in one register and arms the counter by writing a fixed restart key. Once enabled, the counter steps down by one on every bus clock, or only on cycles where an external 1 MHz tick enable is high. If software stops servicing it and the count reaches zero, a timeout event fires. Control bits decide whether that event produces a reset request pulse, a pulse on the external reset trigger, and a sticky interrupt.

The reset-scope field of the control register is driven straight to an output, so that the reset distribution logic outside the block knows which domain to reset. Software reconfigures the block in this order: disable it, write the reload value, write the key, then enable it again. Reads are combinational from the current address.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register reads 0, the reload register reads 0xFFFFFFFF, the counter reads 0xFFFFFFFF, and every event output is low.
- R2: A write of exactly 0x00004755 to the restart register (offset 0x08) loads the reload value into the counter at that clock edge. This applies whether or not counting is enabled.
- R3: A write of any other value to offset 0x08 leaves the counter unchanged.
- R4: While control bit 0 (enable) is clear, the counter holds its value.
- R5: With enable set and control bit 4 clear, the counter decreases by one on every clock.
- R6: With enable set and control bit 4 set, the counter decreases only on clocks where `tick_1mhz` is high.
- R7: When an enabled counter steps from 1 to 0, `timeout_o` is high for exactly the one cycle in which the counter first reads 0. The counter then stays at 0 until it is restarted.
- R8: One cycle after `timeout_o`, `sys_rst_req_o` pulses for one cycle if control bit 1 is set, and `ext_rst_o` pulses for one cycle if control bit 3 is set.
- R9: One cycle after `timeout_o`, `irq_o` is set if control bit 2 is set. It stays set until software writes offset 0x00 with data bit 0 equal to 1. A write there with bit 0 equal to 0 has no effect.
- R10: Control bits 6:5 drive `rst_scope_o` (0 = SoC, 1 = full chip, 2 = CPU only) and read back unchanged.
- R11: Offset 0x00 reads the live counter, 0x04 reads the reload value, 0x08 reads 0, and 0x0C reads the 7-bit control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_1mhz | input | 1 | 1 MHz count enable pulse |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| timeout_o | output | 1 | One-cycle expiry event |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| ext_rst_o | output | 1 | One-cycle external reset trigger |
| irq_o | output | 1 | Sticky timeout interrupt |
| rst_scope_o | output | 2 | Selected reset scope |

## Verification
A register write takes effect at the edge on which it is strobed, so the counter, control fields and `rst_scope_o` are checked on the falling edge right after that edge. Every enabled clock after the enable edge moves the count by one, and each intermediate value is compared on the falling edge of that cycle. `timeout_o` is due on the same falling edge where the count first reads 0. The reset, external and interrupt outputs are due one falling edge later, and the bench samples each output at exactly that edge. Writes that must be ignored are confirmed by reading the counter or by watching `irq_o` on the falling edge after the write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W   = 32;
  localparam int CTRL_W   = 7;
  localparam int OFS_CNT  = 'h0;
  localparam int OFS_LOAD = 'h4;
  localparam int OFS_KICK = 'h8;
  localparam int OFS_CTRL = 'hC;
  localparam logic [DATA_W-1:0] KICK_KEY = 32'h0000_4755;
  localparam int B_EN     = 0;
  localparam int B_RST    = 1;
  localparam int B_IRQ    = 2;
  localparam int B_EXT    = 3;
  localparam int B_TICK   = 4;
  localparam int B_SCOPE  = 5;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DW     = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DW-1:0]     reload_o,
  output logic              restart_o,
  output logic              irq_clr_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0]     reload_q, reload_d;
  logic              sel_cnt, sel_load, sel_kick, sel_ctrl;

  assign sel_cnt  = bus_we && (bus_addr == ADDR_W'(OFS_CNT));
  assign sel_load = bus_we && (bus_addr == ADDR_W'(OFS_LOAD));
  assign sel_kick = bus_we && (bus_addr == ADDR_W'(OFS_KICK));
  assign sel_ctrl = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));

  always_comb begin
    ctrl_d   = ctrl_q;
    reload_d = reload_q;
    if (sel_ctrl) ctrl_d   = bus_wdata[CTRL_W-1:0];
    if (sel_load) reload_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '1;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
    end
  end

  assign restart_o = sel_kick && (bus_wdata == KICK_KEY);
  assign irq_clr_o = sel_cnt && bus_wdata[0];
  assign ctrl_o    = ctrl_q;
  assign reload_o  = reload_q;

  p_ctrl_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ctrl |=> ctrl_q == $past(bus_wdata[CTRL_W-1:0]));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          step,
  input  logic          restart,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] cnt_o,
  output logic          expire_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] cnt_q, cnt_d;
  logic          exp_q, exp_d;
  logic          dec;

  assign dec = en && step && (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    exp_d = 1'b0;
    if (restart) begin
      cnt_d = load_val;
    end else if (dec) begin
      cnt_d = cnt_q - ONE;
      exp_d = (cnt_q == ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = exp_q;

  p_restart_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == $past(load_val));
  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !restart) |=> cnt_q == $past(cnt_q));
  p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !restart) |=> cnt_q == '0);
  p_expire_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |=> !exp_q);
  p_expire_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |-> cnt_q == '0 || $past(restart));
endmodule

// File: rtl/wdog_actions.sv
module wdog_actions (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic act_rst,
  input  logic act_irq,
  input  logic act_ext,
  input  logic irq_clr,
  output logic sys_rst_o,
  output logic ext_o,
  output logic irq_o
);
  logic rst_q, rst_d, ext_q, ext_d, irq_q, irq_d;

  always_comb begin
    rst_d = expire && act_rst;
    ext_d = expire && act_ext;
    irq_d = irq_q;
    if (irq_clr)            irq_d = 1'b0;
    if (expire && act_irq)  irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      ext_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      rst_q <= rst_d;
      ext_q <= ext_d;
      irq_q <= irq_d;
    end
  end

  assign sys_rst_o = rst_q;
  assign ext_o     = ext_q;
  assign irq_o     = irq_q;

  p_rst_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> !rst_q);
  p_ext_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q |=> !ext_q);
  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q);
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(expire));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1mhz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              timeout_o,
  output logic              sys_rst_req_o,
  output logic              ext_rst_o,
  output logic              irq_o,
  output logic [1:0]        rst_scope_o
);
  logic [CTRL_W-1:0] ctrl;
  logic [DATA_W-1:0] reload, cnt;
  logic              restart, irq_clr, step, expire;

  wdog_regs #(.ADDR_W(ADDR_W), .DW(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .ctrl_o(ctrl), .reload_o(reload),
    .restart_o(restart), .irq_clr_o(irq_clr)
  );

  assign step = ctrl[B_TICK] ? tick_1mhz : 1'b1;

  wdog_counter #(.DW(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(ctrl[B_EN]), .step(step),
    .restart(restart), .load_val(reload), .cnt_o(cnt), .expire_o(expire)
  );

  wdog_actions u_act (
    .clk(clk), .rst_n(rst_n), .expire(expire),
    .act_rst(ctrl[B_RST]), .act_irq(ctrl[B_IRQ]), .act_ext(ctrl[B_EXT]),
    .irq_clr(irq_clr), .sys_rst_o(sys_rst_req_o), .ext_o(ext_rst_o),
    .irq_o(irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_CNT))       bus_rdata = cnt;
    else if (bus_addr == ADDR_W'(OFS_LOAD)) bus_rdata = reload;
    else if (bus_addr == ADDR_W'(OFS_CTRL)) bus_rdata = DATA_W'(ctrl);
  end

  assign timeout_o   = expire;
  assign rst_scope_o = ctrl[B_SCOPE+1:B_SCOPE];

  p_rst_follows_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req_o |-> $past(timeout_o));
endmodule

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  localparam logic [3:0] A_CNT = 4'h0, A_LOAD = 4'h4, A_KICK = 4'h8, A_CTRL = 4'hC;
  localparam logic [31:0] KEY = 32'h0000_4755;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1mhz = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        timeout_o, sys_rst_req_o, ext_rst_o, irq_o;
  logic [1:0]  rst_scope_o;
  int n_run = 0, n_fail = 0;

  wdog_timer i_wdog_timer (
    .clk(clk), .rst_n(rst_n), .tick_1mhz(tick_1mhz), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .timeout_o(timeout_o), .sys_rst_req_o(sys_rst_req_o), .ext_rst_o(ext_rst_o),
    .irq_o(irq_o), .rst_scope_o(rst_scope_o)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = A_CNT;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = A_CNT;
  endtask

  task automatic arm(input logic [31:0] load, input logic [31:0] ctl);
    wr(A_CTRL, 32'h0);
    wr(A_LOAD, load);
    wr(A_KICK, KEY);
    wr(A_CTRL, ctl);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_CTRL, d); check("R1 ctrl", d, 32'h0);
    rd(A_LOAD, d); check("R1 reload", d, 32'hFFFF_FFFF);
    rd(A_CNT, d);  check("R1 count", d, 32'hFFFF_FFFF);
    check("R1 outputs", {28'h0, timeout_o, sys_rst_req_o, ext_rst_o, irq_o}, 32'h0);
  endtask

  task automatic t_keys;
    logic [31:0] d;
    wr(A_LOAD, 32'h1234_5678);
    rd(A_LOAD, d); check("R11 reload readback", d, 32'h1234_5678);
    rd(A_KICK, d); check("R11 restart reads zero", d, 32'h0);
    wr(A_LOAD, 32'd7);
    wr(A_KICK, KEY);
    rd(A_CNT, d); check("R2 key loads while disabled", d, 32'd7);
    wr(A_LOAD, 32'd9);
    wr(A_KICK, 32'h0000_4756);
    rd(A_CNT, d); check("R3 wrong key ignored", d, 32'd7);
    wr(A_KICK, 32'h0001_4755);
    rd(A_CNT, d); check("R3 key with high bits ignored", d, 32'd7);
    repeat (4) @(negedge clk);
    rd(A_CNT, d); check("R4 disabled holds", d, 32'd7);
  endtask

  task automatic t_expire_all;
    logic [31:0] d;
    arm(32'd5, 32'h0F);
    rd(A_CNT, d); check("R5 start value", d, 32'd5);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      rd(A_CNT, d); check("R5 per-clock decrement", d, 32'd5 - 32'(k));
    end
    check("R7 timeout at zero", {31'h0, timeout_o}, 32'h1);
    check("R8 no early reset req", {31'h0, sys_rst_req_o}, 32'h0);
    @(negedge clk);
    check("R7 timeout single cycle", {31'h0, timeout_o}, 32'h0);
    check("R8 reset req pulse", {31'h0, sys_rst_req_o}, 32'h1);
    check("R8 ext pulse", {31'h0, ext_rst_o}, 32'h1);
    check("R9 irq set", {31'h0, irq_o}, 32'h1);
    @(negedge clk);
    check("R8 reset req ends", {30'h0, sys_rst_req_o, ext_rst_o}, 32'h0);
    check("R9 irq sticky", {31'h0, irq_o}, 32'h1);
    repeat (3) @(negedge clk);
    rd(A_CNT, d); check("R7 holds at zero", d, 32'h0);
    wr(A_CNT, 32'h0);
    check("R9 clear with bit0=0 ignored", {31'h0, irq_o}, 32'h1);
    wr(A_CNT, 32'h1);
    check("R9 irq cleared", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_masked;
    int nto = 0, nact = 0;
    logic [31:0] d;
    arm(32'd3, 32'h01);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (timeout_o) nto++;
      if (sys_rst_req_o || ext_rst_o || irq_o) nact++;
    end
    check("R7 one timeout pulse", 32'(nto), 32'd1);
    check("R8 actions masked", 32'(nact), 32'd0);
    rd(A_CNT, d); check("R7 zero after masked expiry", d, 32'h0);
  endtask

  task automatic t_tick;
    logic [31:0] d;
    arm(32'd4, 32'h11);
    repeat (3) @(negedge clk);
    rd(A_CNT, d); check("R6 no tick holds", d, 32'd4);
    tick_1mhz = 1'b1;
    @(negedge clk);
    tick_1mhz = 1'b0;
    rd(A_CNT, d); check("R6 tick steps once", d, 32'd3);
    @(negedge clk);
    rd(A_CNT, d); check("R6 holds between ticks", d, 32'd3);
  endtask

  task automatic t_restart_run;
    logic [31:0] d;
    arm(32'd100, 32'h01);
    repeat (3) @(negedge clk);
    rd(A_CNT, d); check("R5 running", d, 32'd97);
    wr(A_KICK, KEY);
    rd(A_CNT, d); check("R2 restart while running", d, 32'd100);
    wr(A_KICK, 32'hDEAD_4755);
    rd(A_CNT, d); check("R3 bad key while running", d, 32'd98);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, d); check("R4 disable edge", d, 32'd96);
    repeat (5) @(negedge clk);
    rd(A_CNT, d); check("R4 stopped", d, 32'd96);
  endtask

  task automatic t_scope;
    logic [31:0] d;
    wr(A_CTRL, 32'h40);
    check("R10 cpu scope", 32'(rst_scope_o), 32'd2);
    rd(A_CTRL, d); check("R10 ctrl readback", d, 32'h40);
    wr(A_CTRL, 32'h20);
    check("R10 full chip scope", 32'(rst_scope_o), 32'd1);
    wr(A_CTRL, 32'h0);
    check("R10 soc scope", 32'(rst_scope_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_keys;
    t_expire_all;
    t_masked;
    t_tick;
    t_restart_run;
    t_scope;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule